// File: doc/BRIEF.md
# Optical Crank-Angle Cylinder Identifier

This block takes the two tracks of an optical crank-angle disk and turns them into cylinder position. The fine track has a slot pattern: each of its rising and falling edges is one angle step, and there are 720 steps per revolution. The coarse track has eight notches whose leading edges are 45 degrees apart. Each leading edge marks top dead centre (TDC) for one cylinder. The coarse track is high while a notch passes.

Both tracks pass through synchronising flops into the system clock domain. The block measures each notch's width in fine-track steps. A notch whose width falls inside a configurable window is the reference notch, and it belongs to the first cylinder in the firing sequence. The block locks at the end of the first reference notch it sees. From then on, a one-hot position register and a cylinder counter advance together at every TDC edge. The block also counts the crank angle within the current cylinder.

An incoming spark trigger is steered to the coil output of the selected cylinder. While the block is hunting for sync, every coil output stays inactive.

Top module: `crank_cyl_id`

## Requirements
- R1: After reset, `synced` is 0, `cyl_num` is 0, `coil_sel` and `coil_out` are all zero, and `angle` is 0.
- R2: At the falling coarse-track edge that ends the first reference notch, `synced` becomes 1, `cyl_num` becomes NUM_CYL (8), and `coil_sel` has only bit NUM_CYL-1 set.
- R3: A notch is a reference notch when its width lies within REF_MIN..REF_MAX, bounds included. Width is the number of fine-track edges seen while the coarse track is high. A notch of any other width never brings the block into sync.
- R4: While synced, each rising coarse-track edge (TDC) moves the cylinder through the order 8, 1, 2, 3, 4, 5, 6, 7 and then back to 8.
- R5: While synced, `coil_sel` has exactly bit `cyl_num`-1 set.
- R6: Every fine-track edge, rising or falling, adds one step to `angle`. `angle` returns to 0 at each TDC and saturates at STEPS_PER_REV/NUM_CYL (90).
- R7: While synced, `coil_out` equals `coil_sel` when `spark_in` is high and is all zero when `spark_in` is low.
- R8: While not synced, `coil_out`, `coil_sel` and `cyl_num` are all zero, whatever `spark_in` does.
- R9: If a reference notch ends while synced and the position register does not point at cylinder 8, `synced` clears. If it does point at cylinder 8, sync is kept.
- R10: If STEPS_PER_REV fine-track edges pass since the last TDC, `synced` clears on the edge that completes that count. One edge fewer leaves sync intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hi_trk | input | 1 | Fine-angle slot track, asynchronous |
| lo_trk | input | 1 | Coarse notch track, asynchronous, high inside a notch |
| spark_in | input | 1 | Spark trigger to be steered to one coil |
| synced | output | 1 | Cylinder position is locked |
| cyl_num | output | 4 | Current cylinder 1..8, 0 while hunting |
| coil_sel | output | 8 | One-hot coil select, bit n-1 for cylinder n |
| coil_out | output | 8 | Steered spark trigger per coil |
| angle | output | 7 | Angle steps since the last TDC, saturating at 90 |

## Verification
The bench keeps 720 steps per revolution and eight cylinders, and narrows the reference window to 12..20 steps. With that window, both bounds can be tested directly: notches of 11 and 21 steps are rejected, and notches of 20 and 12 steps are accepted. The normal notches are 6 steps wide, and a 16-step notch placed at the wrong cylinder exercises the loss of sync. A full revolution of 720 steps keeps the stall test short, so the bench can check the step just before timeout and the step that completes it.

// File: rtl/crank_pkg.sv
package crank_pkg;

  // Tracking state of the cylinder locator.
  typedef enum logic {
    SYNC_HUNT = 1'b0,
    SYNC_LOCK = 1'b1
  } sync_state_e;

  // Synchronised track level plus its value one clock earlier.
  typedef struct packed {
    logic level;
    logic last;
  } trk_view_t;

endpackage

// File: rtl/crank_edge_sync.sv
module crank_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  trk_i,
  output crank_pkg::trk_view_t  view_o
);

  logic [STAGES-1:0] chain_q, chain_d;
  logic              last_q, last_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], trk_i};
    last_d  = chain_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      last_q  <= 1'b0;
    end else begin
      chain_q <= chain_d;
      last_q  <= last_d;
    end
  end

  assign view_o.level = chain_q[STAGES-1];
  assign view_o.last  = last_q;

endmodule

// File: rtl/crank_angle_meter.sv
module crank_angle_meter #(
  parameter int STEPS_PER_REV = 720,
  parameter int NUM_CYL       = 8,
  parameter int REF_MIN       = 20,
  parameter int REF_MAX       = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step_i,
  input  logic notch_lvl_i,
  input  logic tdc_i,
  input  logic notch_end_i,
  output logic [$clog2(STEPS_PER_REV/NUM_CYL+1)-1:0] angle_o,
  output logic ref_notch_o,
  output logic gap_expire_o
);

  localparam int STEPS_PER_CYL = STEPS_PER_REV / NUM_CYL;
  localparam int ANG_W = $clog2(STEPS_PER_CYL + 1);
  localparam int GAP_W = $clog2(STEPS_PER_REV + 1);
  localparam logic [ANG_W-1:0] ANG_MAX  = ANG_W'(STEPS_PER_CYL);
  localparam logic [GAP_W-1:0] GAP_MAX  = GAP_W'(STEPS_PER_REV);
  localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(STEPS_PER_REV - 1);
  localparam logic [GAP_W-1:0] WID_LO   = GAP_W'(REF_MIN);
  localparam logic [GAP_W-1:0] WID_HI   = GAP_W'(REF_MAX);

  logic [ANG_W-1:0] angle_q, angle_d;
  logic [GAP_W-1:0] gap_q, gap_d;
  logic [GAP_W-1:0] wid_q, wid_d;

  always_comb begin
    angle_d = angle_q;
    gap_d   = gap_q;
    wid_d   = wid_q;
    if (tdc_i) begin
      angle_d = '0;
      gap_d   = '0;
      wid_d   = '0;
    end else if (step_i) begin
      if (angle_q != ANG_MAX) angle_d = angle_q + 1'b1;
      if (gap_q != GAP_MAX)   gap_d   = gap_q + 1'b1;
      if (notch_lvl_i && wid_q != GAP_MAX) wid_d = wid_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      angle_q <= '0;
      gap_q   <= '0;
      wid_q   <= '0;
    end else begin
      angle_q <= angle_d;
      gap_q   <= gap_d;
      wid_q   <= wid_d;
    end
  end

  assign angle_o      = angle_q;
  assign ref_notch_o  = notch_end_i && (wid_q >= WID_LO) && (wid_q <= WID_HI);
  assign gap_expire_o = step_i && !tdc_i && (gap_q == GAP_LAST);

  AST_ANGLE_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    angle_q <= ANG_MAX); // R6
  AST_ANGLE_TDC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    tdc_i |=> (angle_q == '0)); // R6
  AST_ANGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !tdc_i && angle_q != ANG_MAX) |=> (angle_q == $past(angle_q) + 1'b1)); // R6

endmodule

// File: rtl/crank_cyl_tracker.sv
module crank_cyl_tracker #(
  parameter int NUM_CYL = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tdc_i,
  input  logic ref_notch_i,
  input  logic gap_expire_i,
  output logic synced_o,
  output logic [NUM_CYL-1:0] hot_o,
  output logic [$clog2(NUM_CYL+1)-1:0] cyl_o
);

  import crank_pkg::*;

  localparam int CYL_W   = $clog2(NUM_CYL + 1);
  localparam int REF_BIT = NUM_CYL - 1;
  localparam logic [CYL_W-1:0]   CYL_LAST  = CYL_W'(NUM_CYL);
  localparam logic [CYL_W-1:0]   CYL_FIRST = CYL_W'(1);
  localparam logic [NUM_CYL-1:0] HOT_ONE   = NUM_CYL'(1);
  localparam logic [NUM_CYL-1:0] HOT_REF   = HOT_ONE << REF_BIT;

  sync_state_e        state_q, state_d;
  logic [NUM_CYL-1:0] hot_q, hot_d;
  logic [CYL_W-1:0]   cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    hot_d   = hot_q;
    cnt_d   = cnt_q;
    if (gap_expire_i) begin
      state_d = SYNC_HUNT;
      hot_d   = '0;
      cnt_d   = '0;
    end else if (state_q == SYNC_HUNT) begin
      if (ref_notch_i) begin
        state_d = SYNC_LOCK;
        hot_d   = HOT_REF;
        cnt_d   = CYL_LAST;
      end
    end else if (ref_notch_i && !hot_q[REF_BIT]) begin
      state_d = SYNC_HUNT;
      hot_d   = '0;
      cnt_d   = '0;
    end else if (tdc_i) begin
      hot_d = {hot_q[NUM_CYL-2:0], hot_q[NUM_CYL-1]};
      cnt_d = (cnt_q == CYL_LAST) ? CYL_FIRST : cnt_q + CYL_FIRST;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SYNC_HUNT;
      hot_q   <= '0;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      hot_q   <= hot_d;
      cnt_q   <= cnt_d;
    end
  end

  assign synced_o = (state_q == SYNC_LOCK);
  assign hot_o    = hot_q;
  assign cyl_o    = cnt_q;

  AST_HOT_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hot_q)); // R4
  AST_HUNT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SYNC_HUNT) |-> (hot_q == '0 && cnt_q == '0)); // R8
  AST_COUNT_AGREES: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SYNC_LOCK) |-> (hot_q == (HOT_ONE << (cnt_q - CYL_FIRST)))); // R5
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SYNC_LOCK && tdc_i && !gap_expire_i) |=>
      (cnt_q == (($past(cnt_q) == CYL_LAST) ? CYL_FIRST : $past(cnt_q) + CYL_FIRST))); // R4
  AST_LOCK_AT_REF: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SYNC_HUNT && ref_notch_i && !gap_expire_i) |=>
      (state_q == SYNC_LOCK && cnt_q == CYL_LAST)); // R2
  AST_DROP_MISPLACED: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SYNC_LOCK && ref_notch_i && !hot_q[REF_BIT]) |=> (state_q == SYNC_HUNT)); // R9
  AST_DROP_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    gap_expire_i |=> (state_q == SYNC_HUNT)); // R10

endmodule

// File: rtl/crank_cyl_id.sv
module crank_cyl_id #(
  parameter int STEPS_PER_REV = 720,
  parameter int NUM_CYL       = 8,
  parameter int REF_MIN       = 20,
  parameter int REF_MAX       = 40,
  parameter int SYNC_STAGES   = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hi_trk,
  input  logic lo_trk,
  input  logic spark_in,
  output logic synced,
  output logic [$clog2(NUM_CYL+1)-1:0] cyl_num,
  output logic [NUM_CYL-1:0] coil_sel,
  output logic [NUM_CYL-1:0] coil_out,
  output logic [$clog2(STEPS_PER_REV/NUM_CYL+1)-1:0] angle
);

  import crank_pkg::*;

  localparam int NUM_TRK = 2;
  localparam int TRK_HI  = 0;
  localparam int TRK_LO  = 1;

  logic [NUM_TRK-1:0] trk_raw;
  trk_view_t          view [NUM_TRK];

  assign trk_raw = {lo_trk, hi_trk};

  for (genvar g = 0; g < NUM_TRK; g++) begin : g_trk
    crank_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .trk_i  (trk_raw[g]),
      .view_o (view[g])
    );
  end

  logic step, tdc, notch_end, notch_lvl;
  logic ref_notch, gap_expire;

  assign step      = view[TRK_HI].level ^ view[TRK_HI].last;
  assign tdc       = view[TRK_LO].level & ~view[TRK_LO].last;
  assign notch_end = ~view[TRK_LO].level & view[TRK_LO].last;
  assign notch_lvl = view[TRK_LO].level;

  crank_angle_meter #(
    .STEPS_PER_REV (STEPS_PER_REV),
    .NUM_CYL       (NUM_CYL),
    .REF_MIN       (REF_MIN),
    .REF_MAX       (REF_MAX)
  ) u_meter (
    .clk          (clk),
    .rst_n        (rst_n),
    .step_i       (step),
    .notch_lvl_i  (notch_lvl),
    .tdc_i        (tdc),
    .notch_end_i  (notch_end),
    .angle_o      (angle),
    .ref_notch_o  (ref_notch),
    .gap_expire_o (gap_expire)
  );

  crank_cyl_tracker #(.NUM_CYL(NUM_CYL)) u_track (
    .clk          (clk),
    .rst_n        (rst_n),
    .tdc_i        (tdc),
    .ref_notch_i  (ref_notch),
    .gap_expire_i (gap_expire),
    .synced_o     (synced),
    .hot_o        (coil_sel),
    .cyl_o        (cyl_num)
  );

  assign coil_out = (spark_in && synced) ? coil_sel : '0;

  AST_COIL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(coil_out)); // R7
  AST_SEL_NEEDS_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    (coil_sel != '0) |-> synced); // R8

endmodule

// File: tb/crank_cyl_id_test.sv
module crank_cyl_id_test;

  localparam int REV  = 720;
  localparam int NCYL = 8;
  localparam int RMIN = 12;
  localparam int RMAX = 20;
  localparam int SEG  = REV / NCYL;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hi_trk = 1'b0;
  logic lo_trk = 1'b0;
  logic spark_in = 1'b0;
  logic       synced;
  logic [3:0] cyl_num;
  logic [7:0] coil_sel;
  logic [7:0] coil_out;
  logic [6:0] angle;

  always #10 clk = ~clk;

  crank_cyl_id #(
    .STEPS_PER_REV (REV),
    .NUM_CYL       (NCYL),
    .REF_MIN       (RMIN),
    .REF_MAX       (RMAX),
    .SYNC_STAGES   (2)
  ) uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .hi_trk   (hi_trk),
    .lo_trk   (lo_trk),
    .spark_in (spark_in),
    .synced   (synced),
    .cyl_num  (cyl_num),
    .coil_sel (coil_sel),
    .coil_out (coil_out),
    .angle    (angle)
  );

  typedef struct {
    logic       s;
    logic [3:0] cyl;
    logic [7:0] sel;
    logic [7:0] coil;
    logic [6:0] ang;
    string      tag;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   fails  = 0;
  bit   done   = 1'b0;

  function automatic logic [7:0] sel_of(input int c);
    return (c == 0) ? 8'h00 : (8'h01 << (c - 1));
  endfunction

  task automatic push(input logic s, input int c, input logic [7:0] coil,
                      input int ang, input string tag);
    exp_t e;
    e.s = s; e.cyl = 4'(c); e.sel = sel_of(c); e.coil = coil;
    e.ang = 7'(ang); e.tag = tag;
    q.push_back(e);
  endtask

  // Monitor: compares expected items against the outputs between edges.
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (synced !== e.s || cyl_num !== e.cyl || coil_sel !== e.sel ||
          coil_out !== e.coil || angle !== e.ang) begin
        fails++;
        $display("FAIL %s: got sync=%0b cyl=%0d sel=%h coil=%h ang=%0d, expected sync=%0b cyl=%0d sel=%h coil=%h ang=%0d",
                 e.tag, synced, cyl_num, coil_sel, coil_out, angle,
                 e.s, e.cyl, e.sel, e.coil, e.ang);
      end
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1 hi_trk = ~hi_trk;
      repeat (4) @(posedge clk);
    end
  endtask

  task automatic lo_set(input logic v);
    @(posedge clk); #1 lo_trk = v;
    repeat (4) @(posedge clk);
  endtask

  task automatic spark(input logic s, input int c, input logic [7:0] coil,
                       input int ang, input string tag);
    @(posedge clk); #1 spark_in = 1'b1;
    push(s, c, coil, ang, tag);
    repeat (2) @(posedge clk);
    #1 spark_in = 1'b0;
    repeat (2) @(posedge clk);
  endtask

  task automatic report;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete, got timeout, expected completion");
      report();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (2) @(posedge clk);
    push(1'b0, 0, 8'h00, 0, "R1 reset state");
    spark(1'b0, 0, 8'h00, 0, "R8 spark ignored while hunting");

    // Notches outside the reference window never lock.
    lo_set(1'b1);
    push(1'b0, 0, 8'h00, 0, "R6 angle zero at TDC");
    step(21);
    lo_set(1'b0);
    push(1'b0, 0, 8'h00, 21, "R3 width 21 rejected");
    step(SEG - 21);
    lo_set(1'b1); step(11); lo_set(1'b0);
    push(1'b0, 0, 8'h00, 11, "R3 width 11 rejected");
    step(SEG - 11);

    // Upper bound of the window locks at the first reference notch.
    lo_set(1'b1); step(20); lo_set(1'b0);
    push(1'b1, 8, 8'h00, 20, "R2 R3 lock at width 20");
    step(SEG - 20);

    for (int c = 1; c < NCYL; c++) begin
      lo_set(1'b1);
      push(1'b1, c, 8'h00, 0, "R4 R5 advance at TDC");
      step(6);
      lo_set(1'b0);
      if (c == 3) spark(1'b1, 3, 8'h04, 6, "R7 spark to coil 3");
      step(SEG - 6);
      if (c == 3) begin
        step(5);
        push(1'b1, 3, 8'h00, SEG, "R6 angle saturates");
      end
    end

    // Lower bound of the window, at the expected place: sync kept.
    lo_set(1'b1);
    push(1'b1, 8, 8'h00, 0, "R4 wrap to cylinder 8");
    step(12); lo_set(1'b0);
    push(1'b1, 8, 8'h00, 12, "R3 R9 on-time width 12 keeps sync");
    step(SEG - 12);

    lo_set(1'b1);
    push(1'b1, 1, 8'h00, 0, "R4 after wrap");
    step(6); lo_set(1'b0); step(SEG - 6);

    // Reference notch at cylinder 2 drops sync.
    lo_set(1'b1);
    push(1'b1, 2, 8'h00, 0, "R4 cylinder 2");
    step(16); lo_set(1'b0);
    push(1'b0, 0, 8'h00, 16, "R9 misplaced reference drops sync");
    step(SEG - 16);
    spark(1'b0, 0, 8'h00, SEG, "R8 spark ignored after loss");

    // Relock, then stall the coarse track for a full revolution.
    lo_set(1'b1); step(16); lo_set(1'b0);
    push(1'b1, 8, 8'h00, 16, "R2 relock at first reference");
    step(REV - 1 - 16);
    push(1'b1, 8, 8'h00, SEG, "R10 still synced one step short");
    step(1);
    push(1'b0, 0, 8'h00, SEG, "R10 stall drops sync");

    repeat (3) @(posedge clk);
    wait (q.size() == 0);
    @(posedge clk);
    done = 1'b1;
    report();
  end

endmodule